// File: doc/BRIEF.md
# SRAM Bank Select with Power-Fail Gating

This block sits between a host bus and two external static RAM banks. While the supply is healthy, it decodes an external enable and a single bank-select address bit into two active-low chip enables, so that at most one bank is enabled. It also decodes the access strobes for a small set of internal registers into a write pulse and a data-output enable.

A power monitor outside the block reports the supply condition as a two-bit code, with `00` meaning normal. The block registers this code. When the supply is not normal, both bank enables are forced inactive, register writes are blocked and the data outputs are released, whatever the bus is doing. The access state machine has three states:

- `ST_DESELECT`: supply out of tolerance.
- `ST_WAIT_IDLE`: supply is back, but the bus has not yet gone idle.
- `ST_VALID`: normal access.

Its transitions are:

- T_FAIL: any state goes to `ST_DESELECT` when the registered code is not `00`.
- T_RESTORE: `ST_DESELECT` goes to `ST_WAIT_IDLE` when the registered code is `00`.
- T_RELEASE: `ST_WAIT_IDLE` goes to `ST_VALID` when both enables are seen high at a clock edge.

Because of this, a strobe that spans the recovery can never finish a write.

A single active-low reset output combines three sources:

- A hold timer that asserts at once on a power failure and keeps the output low for `HOLD_TICKS` clock-enable ticks after the supply returns.
- Two external reset inputs, each synchronized and debounced for `DEB_CYCLES` clocks.

Top module: `sram_bank_gate`

## Requirements
- R1: In `ST_VALID`, with `ext_ce_n` low and `bank_sel` low, `bank1_ce_n` is 0 and `bank2_ce_n` is 1.
- R2: In `ST_VALID`, with `ext_ce_n` low and `bank_sel` high, `bank1_ce_n` is 1 and `bank2_ce_n` is 0.
- R3: With `ext_ce_n` high, both bank enables are 1 for either value of `bank_sel`.
- R4: When `pwr_state` is any code other than `00` (`01` below threshold, `10` battery, `11` reserved and also treated as a failure), then from the second clock edge on, both bank enables are 1 and `reg_wr_en` and `dq_oe` are 0. Bus inputs have no effect.
- R5: After `pwr_state` returns to `00`, accesses stay blocked until `cs_n` and `ext_ce_n` are both high at a clock edge. A write strobe held low across recovery never raises `reg_wr_en`.
- R6: In `ST_VALID`, `reg_wr_en` is 1 exactly when `cs_n` and `we_n` are low. `dq_oe` is 1 exactly when `cs_n` and `oe_n` are low and `we_n` is high.
- R7: `reset_out_n` is 0 after the first clock edge that samples a non-`00` `pwr_state`.
- R8: `reset_out_n` stays 0 until `HOLD_TICKS` ticks have been counted after the registered power code becomes `00`. It then returns to 1 if neither reset input is asserted.
- R9: A reset input held low for `DEB_CYCLES` synchronized clocks drives `reset_out_n` to 0. Shorter low pulses are ignored. Both inputs are inactive when high.
- R10: While `rst_n` is low, the block is in `ST_DESELECT`, both bank enables are 1, `reg_wr_en` and `dq_oe` are 0, and `reset_out_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Clock enable for the reset hold timer |
| pwr_state | input | 2 | Supply code: 00 normal, 01 below threshold, 10 battery, 11 reserved |
| ext_ce_n | input | 1 | Active-low external SRAM enable |
| bank_sel | input | 1 | Bank select address bit (0 selects bank 1) |
| cs_n | input | 1 | Active-low register chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| rst_in_a_n | input | 1 | External reset input A, active low |
| rst_in_b_n | input | 1 | External reset input B, active low |
| bank1_ce_n | output | 1 | Active-low enable for SRAM bank 1 |
| bank2_ce_n | output | 1 | Active-low enable for SRAM bank 2 |
| reg_wr_en | output | 1 | Internal register write strobe |
| dq_oe | output | 1 | Data bus drive enable |
| reset_out_n | output | 1 | Active-low system reset output |

## Verification
The hardest state to reach is `ST_WAIT_IDLE` with a write already in progress. That state only exists when power returns while `cs_n` and `we_n` are still held low from before the failure. The stimulus starts a write in `ST_VALID` and then applies each failure code in turn. It returns the code to `00` with the strobes still low, confirms over several cycles that no write pulse appears, and then shows that one idle edge reopens access. The reset hold window is checked on both sides of its expected release, with ticks arriving at a known slower rate.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    typedef enum logic [1:0] {
        PWR_NORMAL = 2'b00,
        PWR_LOW    = 2'b01,
        PWR_BATT   = 2'b10,
        PWR_RSVD   = 2'b11
    } pwr_code_e;

    typedef enum logic [1:0] {
        ST_DESELECT  = 2'd0,
        ST_WAIT_IDLE = 2'd1,
        ST_VALID     = 2'd2
    } acc_state_e;

endpackage

// File: rtl/sbg_rst_filter.sv
module sbg_rst_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic asserted
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic          meta_q;
    logic          sync_q;
    logic          filt_q;
    logic [CW-1:0] cnt_q;

    // two-stage synchronizer, idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= raw_n;
            sync_q <= meta_q;
        end
    end

    // accept a new level only after it has been stable for DEB_CYCLES clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_q != filt_q) begin
            if (cnt_q == LAST) begin
                filt_q <= sync_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign asserted = !filt_q;
endmodule

// File: rtl/sbg_por_hold.sv
module sbg_por_hold #(
    parameter int HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_fail,
    output logic hold
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] DONE = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pwr_fail) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != DONE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // failure asserts at once; release waits for the full tick count
    assign hold = pwr_fail || (cnt_q != DONE);
endmodule

// File: rtl/sbg_access_fsm.sv
module sbg_access_fsm
    import sbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_fail,
    input  logic       ext_ce_n,
    input  logic       bank_sel,
    input  logic       cs_n,
    input  logic       we_n,
    input  logic       oe_n,
    output acc_state_e state,
    output logic       bank1_ce_n,
    output logic       bank2_ce_n,
    output logic       reg_wr_en,
    output logic       dq_oe
);
    acc_state_e state_q;
    acc_state_e state_d;
    logic       bus_idle;

    assign bus_idle = cs_n && ext_ce_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESELECT;
        else        state_q <= state_d;
    end

    // transitions T_FAIL, T_RESTORE, T_RELEASE
    always_comb begin
        state_d = state_q;
        if (pwr_fail) begin
            state_d = ST_DESELECT;
        end else begin
            unique case (state_q)
                ST_DESELECT:  state_d = ST_WAIT_IDLE;
                ST_WAIT_IDLE: if (bus_idle) state_d = ST_VALID;
                ST_VALID:     state_d = ST_VALID;
                default:      state_d = ST_DESELECT;
            endcase
        end
    end

    // outputs
    always_comb begin
        bank1_ce_n = 1'b1;
        bank2_ce_n = 1'b1;
        reg_wr_en  = 1'b0;
        dq_oe      = 1'b0;
        unique case (state_q)
            ST_VALID: begin
                bank1_ce_n = ext_ce_n || bank_sel;
                bank2_ce_n = ext_ce_n || !bank_sel;
                reg_wr_en  = !cs_n && !we_n;
                dq_oe      = !cs_n && !oe_n && we_n;
            end
            ST_DESELECT, ST_WAIT_IDLE: begin
                bank1_ce_n = 1'b1;
                bank2_ce_n = 1'b1;
            end
            default: begin
                bank1_ce_n = 1'b1;
                bank2_ce_n = 1'b1;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/sram_bank_gate.sv
module sram_bank_gate
    import sbg_pkg::*;
#(
    parameter int DEB_CYCLES = 16,
    parameter int HOLD_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] pwr_state,
    input  logic       ext_ce_n,
    input  logic       bank_sel,
    input  logic       cs_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       rst_in_a_n,
    input  logic       rst_in_b_n,
    output logic       bank1_ce_n,
    output logic       bank2_ce_n,
    output logic       reg_wr_en,
    output logic       dq_oe,
    output logic       reset_out_n
);
    localparam int NRST = 2;

    pwr_code_e  pwr_q;
    logic       pwr_fail;
    acc_state_e acc_state;
    logic       por_hold;
    logic [NRST-1:0] rin_n;
    logic [NRST-1:0] rin_asserted;

    // registered supply status; reset value is a failure
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= PWR_BATT;
        else        pwr_q <= pwr_code_e'(pwr_state);
    end

    assign pwr_fail = (pwr_q != PWR_NORMAL);

    sbg_access_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_fail   (pwr_fail),
        .ext_ce_n   (ext_ce_n),
        .bank_sel   (bank_sel),
        .cs_n       (cs_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .state      (acc_state),
        .bank1_ce_n (bank1_ce_n),
        .bank2_ce_n (bank2_ce_n),
        .reg_wr_en  (reg_wr_en),
        .dq_oe      (dq_oe)
    );

    sbg_por_hold #(.HOLD_TICKS(HOLD_TICKS)) u_por (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pwr_fail (pwr_fail),
        .hold     (por_hold)
    );

    assign rin_n = {rst_in_b_n, rst_in_a_n};

    for (genvar i = 0; i < NRST; i++) begin : g_rin
        sbg_rst_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_n    (rin_n[i]),
            .asserted (rin_asserted[i])
        );
    end

    assign reset_out_n = !(por_hold || (|rin_asserted));
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker
    import sbg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pwr_state,
    input logic       ext_ce_n,
    input logic       cs_n,
    input logic       we_n,
    input logic       bank1_ce_n,
    input logic       bank2_ce_n,
    input logic       reg_wr_en,
    input logic       dq_oe,
    input logic       reset_out_n,
    input acc_state_e state
);
    AST_ONE_BANK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!bank1_ce_n, !bank2_ce_n})); // R1

    AST_EXT_HIGH_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ce_n |-> (bank1_ce_n && bank2_ce_n)); // R3

    AST_FAIL_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'b00) |=> ##1 (bank1_ce_n && bank2_ce_n && !reg_wr_en && !dq_oe)); // R4

    AST_RECOVER_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_IDLE && !(cs_n && ext_ce_n)) |=> (state != ST_VALID)); // R5

    AST_WRITE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (!cs_n && !we_n && !dq_oe)); // R6

    AST_FAIL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'b00) |=> !reset_out_n); // R7
endmodule

bind sram_bank_gate sbg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_state   (pwr_state),
    .ext_ce_n    (ext_ce_n),
    .cs_n        (cs_n),
    .we_n        (we_n),
    .bank1_ce_n  (bank1_ce_n),
    .bank2_ce_n  (bank2_ce_n),
    .reg_wr_en   (reg_wr_en),
    .dq_oe       (dq_oe),
    .reset_out_n (reset_out_n),
    .state       (acc_state)
);

// File: tb/sram_bank_gate_test.sv
`timescale 1ns/1ps
module sram_bank_gate_test;
    localparam int DEB = 4;
    localparam int HOLD = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] pwr_state = 2'b00;
    logic       ext_ce_n = 1'b1, bank_sel = 1'b0, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic       rst_in_a_n = 1'b1, rst_in_b_n = 1'b1;
    logic       bank1_ce_n, bank2_ce_n, reg_wr_en, dq_oe, reset_out_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    sram_bank_gate #(.DEB_CYCLES(DEB), .HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_state(pwr_state),
        .ext_ce_n(ext_ce_n), .bank_sel(bank_sel), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .rst_in_a_n(rst_in_a_n), .rst_in_b_n(rst_in_b_n),
        .bank1_ce_n(bank1_ce_n), .bank2_ce_n(bank2_ce_n), .reg_wr_en(reg_wr_en),
        .dq_oe(dq_oe), .reset_out_n(reset_out_n)
    );

    always #5 clk = ~clk;

    // tick every fourth clock
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            tick = (tc % 4 == 0);
        end
    end

    // {ext_ce_n, bank_sel, cs_n, we_n, oe_n, exp_b1, exp_b2, exp_wr, exp_oe}
    localparam logic [8:0] VECS [0:7] = '{
        9'b0_0_1_1_1_0_1_0_0,
        9'b0_1_1_1_1_1_0_0_0,
        9'b1_0_1_1_1_1_1_0_0,
        9'b1_1_0_0_1_1_1_1_0,
        9'b0_0_0_0_0_0_1_1_0,
        9'b0_1_0_1_0_1_0_0_1,
        9'b1_0_0_1_1_1_1_0_0,
        9'b0_1_1_0_0_1_0_0_0
    };

    task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {bank1_ce_n, bank2_ce_n, reg_wr_en, dq_oe};
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cycles(3);
        // R10 reset state
        chk(outs() == 4'b1100, "R10 outputs in reset", outs(), 4'b1100);
        chk(reset_out_n == 1'b0, "R10 reset_out_n in reset", {3'b0, reset_out_n}, 4'b0);
        rst_n = 1'b1;
        cycles(5);

        // R1 R2 R3 R6 vector table in the valid state
        foreach (VECS[i]) begin
            @(negedge clk);
            {ext_ce_n, bank_sel, cs_n, we_n, oe_n} = VECS[i][8:4];
            #1;
            chk(outs() == VECS[i][3:0], $sformatf("R1 R2 R3 R6 vector %0d", i), outs(), VECS[i][3:0]);
        end

        // R4 / R5 / R8 for each failure code
        for (int c = 1; c < 4; c++) begin
            @(negedge clk);
            ext_ce_n = 1'b0; bank_sel = 1'b0; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
            #1;
            chk(outs() == 4'b0110, "R6 write before failure", outs(), 4'b0110);
            @(negedge clk);
            pwr_state = 2'(c);
            cycles(2);
            chk(outs() == 4'b1100, $sformatf("R4 blocked code %0d", c), outs(), 4'b1100);
            bank_sel = 1'b1; we_n = 1'b1; oe_n = 1'b0;
            #1;
            chk(outs() == 4'b1100, "R4 inputs ignored", outs(), 4'b1100);
            chk(reset_out_n == 1'b0, "R7 reset during failure", {3'b0, reset_out_n}, 4'b0);
            bank_sel = 1'b0; we_n = 1'b0; oe_n = 1'b1;
            @(negedge clk);
            pwr_state = 2'b00;
            cycles(6);
            chk(outs() == 4'b1100, "R5 held write stays blocked", outs(), 4'b1100);
            chk(reset_out_n == 1'b0, "R8 reset held after recovery", {3'b0, reset_out_n}, 4'b0);
            cs_n = 1'b1; ext_ce_n = 1'b1;
            @(negedge clk);
            cs_n = 1'b0; we_n = 1'b0; ext_ce_n = 1'b0; bank_sel = 1'b1;
            #1;
            chk(outs() == 4'b1010, "R5 access after idle edge", outs(), 4'b1010);
        end

        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; ext_ce_n = 1'b1;
        cycles(30);
        chk(reset_out_n == 1'b1, "R8 reset released after hold", {3'b0, reset_out_n}, 4'b1);

        // R7 immediate assertion
        pwr_state = 2'b01;
        cycles(1);
        chk(reset_out_n == 1'b0, "R7 reset after one edge", {3'b0, reset_out_n}, 4'b0);
        pwr_state = 2'b00;
        cycles(30);
        chk(reset_out_n == 1'b1, "R8 released again", {3'b0, reset_out_n}, 4'b1);

        // R9 short glitch ignored
        begin
            bit seen_low = 1'b0;
            rst_in_a_n = 1'b0;
            cycles(2);
            rst_in_a_n = 1'b1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (!reset_out_n) seen_low = 1'b1;
            end
            chk(!seen_low, "R9 short pulse ignored", {3'b0, !seen_low}, 4'b1);
        end

        // R9 long pulse asserts, then releases
        rst_in_b_n = 1'b0;
        cycles(10);
        chk(reset_out_n == 1'b0, "R9 long pulse on input b", {3'b0, reset_out_n}, 4'b0);
        rst_in_b_n = 1'b1;
        cycles(10);
        chk(reset_out_n == 1'b1, "R9 release input b", {3'b0, reset_out_n}, 4'b1);
        rst_in_a_n = 1'b0;
        cycles(10);
        chk(reset_out_n == 1'b0, "R9 long pulse on input a", {3'b0, reset_out_n}, 4'b0);
        rst_in_a_n = 1'b1;
        cycles(10);
        chk(reset_out_n == 1'b1, "R9 release input a", {3'b0, reset_out_n}, 4'b1);

        finish_run();
    end
endmodule